// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and a 128K x 8 asynchronous static RAM. The RAM has two chip selects of opposite polarity, an output enable, a write enable and a shared data bus. The host hands over one word-wide read or write at a time through a valid/ready request channel. The controller then plays out the strobe sequence for that access on the memory pins, paced by timing budgets in nanoseconds that are rounded up to whole clock cycles. Read results come back on a single-cycle response strobe.

The request channel follows valid/ready rules. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. Fields must stay stable while `req_valid` waits for ready. `req_ready` is high only while the controller is idle, and it drops from the accepting edge until the access and any bus turn-around have finished. The response channel has no back-pressure, so the host must take `rsp_data` in the one cycle that `rsp_valid` is high. The shared data bus is shown as separate in, out and enable signals; the tri-state pad sits outside this block.

A level-sensitive sleep input puts the memory into its low-current retention state by deselecting it on both selects. When sleep is released, a recovery count must expire before any request is taken again.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_cs_n` is 1, `mem_cs` is 1, `mem_oe_n` is 1, `mem_we_n` is 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the access completes, and a request held valid during that time is taken only once.
- R3: A read drives `mem_cs_n`=0, `mem_cs`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD cycles, where RD is the larger of the rounded-up read cycle and output-enable access times. `mem_addr` is held stable for the whole access.
- R4: Read data is sampled from `mem_dq_in` at the end of the last read cycle. `rsp_valid` is high for one cycle, RD cycles after the accepting edge.
- R5: After every read, the chip is deselected with `mem_oe_n`=1 and `mem_dq_oe`=0 for exactly TA cycles (rounded-up bus turn-around) before `req_ready` returns to 1.
- R6: A write keeps `mem_cs_n`=0 and `mem_cs`=1 for WC cycles and holds `mem_we_n`=0 in the final WP of them. The pulse ends on the same edge that deselects the chip, and the word is written to `mem_addr`.
- R7: `mem_dq_oe` is 1 only in the final DW cycles of a write pulse, while `mem_oe_n`=1 and the chip is selected. It is 0 in every other state.
- R8: When `sleep_req` is 1 while idle and no request is being taken, the controller enters retention with `mem_cs_n`=1, `mem_cs`=0 and `req_ready`=0. A request presented during retention is not taken.
- R9: After `sleep_req` falls, `mem_cs` returns to 1 and `req_ready` stays 0 for exactly REC cycles. Memory contents written before sleep read back unchanged.
- R10: Each timing budget rounds up to whole clock periods. With a 5 ns clock, 38 ns gives 8 cycles and 21 ns gives 5 cycles.
- R11: When `sleep_req` rises during an access, retention begins only after the access and its turn-around are complete, on the first edge after the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` holds read data |
| rsp_data | output | 8 | Captured read data |
| sleep_req | input | 1 | Level request for retention mode |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select; low in retention |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Data driver enable toward memory |
| mem_dq_in | input | 8 | Data from memory |

## Verification
Counting the accepting edge as edge 0, a read response is due in the cycle after edge RD. The driver stores that cycle number next to the expected byte, and the monitor checks both when the strobe appears. Strobe run lengths (RD, WC, WP, DW) and the turn-around of TA idle cycles are counted on falling edges from the pin levels. Each is compared when the chip deselects. The recovery window is counted from the cycle after sleep is released and must equal REC. For a sleep request raised during a read, retention must show up exactly RD+TA+1 edges after acceptance.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_SLEEP,
    ST_WAKE
  } ctl_state_e;

  // Round a budget in ns up to whole clock periods, never below one cycle.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             zero
);

  always_comb begin
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int RD_CYC  = 11,
  parameter int WC_CYC  = 11,
  parameter int WP_CYC  = 8,
  parameter int DW_CYC  = 5,
  parameter int TA_CYC  = 5,
  parameter int REC_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic sleep_req,
  output logic req_ready,
  output logic accept,
  output logic rd_last,
  output logic mem_cs_n,
  output logic mem_cs,
  output logic mem_oe_n,
  output logic mem_we_n,
  output logic mem_dq_oe
);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WC_LD  = CNT_W'(WC_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LIM = CNT_W'(WP_CYC);
  localparam logic [CNT_W-1:0] DW_LIM = CNT_W'(DW_CYC);

  ctl_state_e       state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             zero;

  sram_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .zero     (zero)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_last   = (state_q == ST_READ) && zero;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && req_write) begin
          state_d = ST_WRITE; load = 1'b1; load_val = WC_LD;
        end else if (accept) begin
          state_d = ST_READ;  load = 1'b1; load_val = RD_LD;
        end else if (sleep_req) begin
          state_d = ST_SLEEP;
        end
      end
      ST_READ: if (zero) begin
        state_d = ST_TURN; load = 1'b1; load_val = TA_LD;
      end
      ST_TURN:  if (zero) state_d = ST_IDLE;
      ST_WRITE: if (zero) state_d = ST_IDLE;
      ST_SLEEP: if (!sleep_req) begin
        state_d = ST_WAKE; load = 1'b1; load_val = REC_LD;
      end
      ST_WAKE:  if (zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Pin levels are registered from the next state and count, so they line up with state_q.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      state_q   <= state_d;
      mem_cs_n  <= !((state_d == ST_READ) || (state_d == ST_WRITE));
      mem_cs    <= (state_d != ST_SLEEP);
      mem_oe_n  <= (state_d != ST_READ);
      mem_we_n  <= !((state_d == ST_WRITE) && (cnt_d < WP_LIM));
      mem_dq_oe <= (state_d == ST_WRITE) && (cnt_d < DW_LIM);
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_drive_in_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n && mem_cs && mem_oe_n));

  p_no_oe_we_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  p_retention_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |-> (mem_cs_n && !mem_cs && !req_ready));

  p_wake_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs) |-> !req_ready);

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_last,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_last;
      if (rd_last) rsp_data <= mem_dq_in;
    end
  end

  p_rsp_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_RC_NS   = 55,
  parameter int T_OE_NS   = 30,
  parameter int T_WC_NS   = 55,
  parameter int T_WP_NS   = 40,
  parameter int T_DW_NS   = 25,
  parameter int T_TA_NS   = 25,
  parameter int T_REC_NS  = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              sleep_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC  = imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int DW_CYC  = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int WP_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS), DW_CYC);
  localparam int WC_CYC  = imax(ns_to_cyc(T_WC_NS, CLK_NS), WP_CYC);
  localparam int TA_CYC  = ns_to_cyc(T_TA_NS, CLK_NS);
  localparam int REC_CYC = ns_to_cyc(T_REC_NS, CLK_NS);
  localparam int CNT_MAX = imax(imax(RD_CYC, WC_CYC), imax(TA_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic accept;
  logic rd_last;

  sram_ctrl_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WC_CYC  (WC_CYC),
    .WP_CYC  (WP_CYC),
    .DW_CYC  (DW_CYC),
    .TA_CYC  (TA_CYC),
    .REC_CYC (REC_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .sleep_req (sleep_req),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_last   (rd_last),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_ctrl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_last    (rd_last),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  p_select_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_cs_n && !mem_cs));

endmodule

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;

  // Expected cycle counts with a 5 ns clock: 55->11, 52->11, 38->8, 21->5, 25->5, 100->20
  localparam int RD  = 11;
  localparam int WC  = 11;
  localparam int WP  = 8;
  localparam int DW  = 5;
  localparam int TA  = 5;
  localparam int REC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        sleep_req = 1'b0;
  logic [16:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  always #2.5 clk = ~clk;

  sram_ctrl #(
    .CLK_NS(5), .T_RC_NS(55), .T_OE_NS(30), .T_WC_NS(52), .T_WP_NS(38),
    .T_DW_NS(21), .T_TA_NS(25), .T_REC_NS(100)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sleep_req(sleep_req),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_data [$];
  int         exp_cyc [$];

  function automatic logic [7:0] dflt(input int a);
    return 8'((a * 13 + 7) & 255);
  endfunction

  function automatic logic [7:0] mem_get(input int a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction

  function automatic logic [7:0] shadow_get(input int a);
    return shadow.exists(a) ? shadow[a] : dflt(a);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model and pin monitor, evaluated on the falling edge
  int sel_run = 0, we_run = 0, drv_run = 0, oe_run = 0;
  bit wr_prev = 0;
  int wr_addr = 0;
  logic [7:0] wr_dat = '0;
  bit in_ta = 0;
  int ta_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit wr_now;
      wr_now = !mem_cs_n && mem_cs && !mem_we_n;
      if (wr_now) wr_addr = int'(mem_addr);
      if (wr_now && mem_dq_oe) wr_dat = mem_dq_out;
      if (wr_prev && !wr_now) mem[wr_addr] = wr_dat;
      wr_prev = wr_now;
      mem_dq_in <= (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n) ? mem_get(int'(mem_addr)) : 8'hEE;

      if (in_ta) begin
        if (req_ready) begin
          check(ta_cnt == TA, "R5 turn-around cycles", ta_cnt, TA);
          check(mem_dq_oe == 1'b0, "R7 driver off at turn-around end", int'(mem_dq_oe), 0);
          in_ta = 0;
        end else ta_cnt++;
      end

      if (!mem_cs_n) begin
        sel_run++;
        if (!mem_we_n) we_run++;
        if (mem_dq_oe) drv_run++;
        if (!mem_oe_n) oe_run++;
      end else if (sel_run > 0) begin
        if (we_run > 0) begin
          check(sel_run == WC, "R6 write select cycles", sel_run, WC);
          check(we_run == WP, "R6/R10 write pulse cycles", we_run, WP);
          check(drv_run == DW, "R7/R10 data drive cycles", drv_run, DW);
          check(oe_run == 0, "R6 output enable idle in write", oe_run, 0);
        end else begin
          check(sel_run == RD && oe_run == RD, "R3 read strobe cycles", oe_run, RD);
          check(drv_run == 0, "R7 no drive in read", drv_run, 0);
          in_ta = 1; ta_cnt = 1;
        end
        sel_run = 0; we_run = 0; drv_run = 0; oe_run = 0;
      end

      if (rsp_valid) begin
        if (exp_data.size() == 0) begin
          check(0, "R2 unexpected response", 1, 0);
        end else begin
          logic [7:0] ed;
          int ec;
          ed = exp_data.pop_front();
          ec = exp_cyc.pop_front();
          check(rsp_data == ed, "R4 read data", int'(rsp_data), int'(ed));
          check(cyc == ec, "R4 response cycle", cyc, ec);
        end
      end
    end
  end

  int last_acc = 0;

  task automatic send(input bit wr, input int a, input logic [7:0] d, input int hold);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 17'(a); req_wdata = d;
    last_acc = cyc + 1;
    if (wr) shadow[a] = d;
    else begin
      exp_data.push_back(shadow_get(a));
      exp_cyc.push_back(last_acc + RD);
    end
    repeat (hold + 1) @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(mem_cs_n == 1'b1 && mem_cs == 1'b1, "R1 deselected after reset", int'({mem_cs_n, mem_cs}), 3);
    check(mem_oe_n == 1'b1 && mem_we_n == 1'b1, "R1 strobes idle after reset", int'({mem_oe_n, mem_we_n}), 3);
    check(mem_dq_oe == 1'b0 && rsp_valid == 1'b0, "R1 driver and response idle", int'({mem_dq_oe, rsp_valid}), 0);

    // Writes at both address ends and in the middle
    send(1, 'h00000, 8'hA5, 0);
    send(1, 'h1FFFF, 8'h3C, 0);
    send(1, 'h12345, 8'hFF, 0);
    // Reads, including an address never written
    send(0, 'h00000, 8'h00, 0);
    send(0, 'h1FFFF, 8'h00, 0);
    send(0, 'h12345, 8'h00, 0);
    send(0, 'h00100, 8'h00, 0);
    // Read then write then read of one address; valid held while busy
    send(0, 'h0ABCD, 8'h00, 6);
    send(1, 'h0ABCD, 8'h5A, 7);
    send(0, 'h0ABCD, 8'h00, 0);

    // R8: retention from idle; a waiting request is not taken
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    check(mem_cs_n == 1'b1 && mem_cs == 1'b0, "R8 retention pins", int'({mem_cs_n, mem_cs}), 2);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_wdata = 8'h99;
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (req_ready) seen++;
      end
      check(seen == 0, "R8 ready low in retention", seen, 0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    sleep_req = 1'b0;
    begin
      int blocked = 0;
      @(negedge clk);
      check(mem_cs == 1'b1, "R9 select restored on wake", int'(mem_cs), 1);
      while (!req_ready && blocked < 200) begin
        blocked++;
        @(negedge clk);
      end
      check(blocked == REC, "R9 recovery cycles", blocked, REC);
    end
    // R9 retention of contents; R8 the refused write left no trace
    send(0, 'h00042, 8'h00, 0);
    send(0, 'h1FFFF, 8'h00, 0);

    // R11: sleep raised during a read waits for the turn-around
    send(0, 'h12345, 8'h00, 0);
    sleep_req = 1'b1;
    while (mem_cs == 1'b1 && cyc < last_acc + 100) @(negedge clk);
    check(cyc == last_acc + RD + TA + 1, "R11 deferred retention edge", cyc, last_acc + RD + TA + 1);
    sleep_req = 1'b0;
    send(0, 'h00000, 8'h00, 0);

    repeat (30) @(negedge clk);
    check(exp_data.size() == 0, "R2 R4 every read answered once", exp_data.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule